// File: doc/BRIEF.md
# Keyboard Controller Command Front End

This block is the host-side command and data decoder of a PC-style keyboard and mouse controller. The host reaches it over a byte-wide write path with two targets. A write to the command target is decoded as a controller command. A write to the data target is either the operand of a command that is still waiting for one, or a byte to pass on to the keyboard. The block owns the mode register, the output port register and the static part of the status byte. It also holds a one-entry latch that records which two-step command is waiting for its operand.

Controller replies leave the block as single-cycle response strobes, which go to an external output-buffer arbiter. Bytes bound for the keyboard or the mouse leave as valid-only strobes, which go to the serial line engines. The block drives the A20 gate level, a one-cycle system reset request, a scan-code translation enable, and two one-cycle hints. One hint tells the interrupt logic to re-read the mode bits. The other asks the arbiter to look again for pending device data.

All outputs are registered. The result of a write shows on the outputs in the cycle after the clock edge that captures that write.

Top module: `kbc_cmd_front`

## Requirements
- R1: After reset, mode_o is 0x03, status_o is 0x18, outport_o is 0xCF and a20_o is 1. Every strobe output is 0.
- R2: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 change no output. They only record a pending operand. The next data write is consumed as that operand, and the pending record is then cleared. A later deferred command replaces an earlier one that has not yet received its operand.
- R3: Each of these commands produces one response strobe with resp_aux_o = 0:
  - 0x20 returns mode_o.
  - 0xD0 returns outport_o.
  - 0xC0 returns 0x80.
  - 0xA9 and 0xAB return 0x00.
  - 0xAA returns 0x55 and also sets status_o bit 2.
- R4: Command 0xA7 sets mode bit 5 (auxiliary disable) and 0xA8 clears it. Command 0xAD sets mode bit 4 (keyboard disable) and 0xAE clears it. Each of the two enable commands (0xA8 and 0xAE) also pulses pend_eval_o.
- R5: A command with bits 7:4 = 0xF is a pulse command. If its bit 0 is 0, it pulses sys_reset_o. If its bit 0 is 1, it has no effect at all.
- R6: Command 0xDF sets outport bit 1 and a20_o. Command 0xDD clears both.
- R7: The operand of 0xD1 replaces outport_o, and a20_o follows bit 1 of the new value. If bit 0 of the operand is 0, sys_reset_o pulses.
- R8: A data write with no pending operand has three effects: it strobes kbd_tx_valid_o with the byte, clears mode bit 4, and pulses pend_eval_o.
- R9: The operand of 0xD4 has three effects: it strobes aux_tx_valid_o with the byte, clears mode bit 5, and pulses pend_eval_o.
- R10: The operand of 0x60 replaces mode_o and pulses both irq_refresh_o and pend_eval_o. xlate_en_o always equals mode bit 6.
- R11: The operand of 0xD2 is returned as a response with resp_aux_o = 0. The operand of 0xD3 is returned as a response with resp_aux_o = 1.
- R12: Any other command code pulses unsup_o. It leaves mode, output port, status and the pending record unchanged.
- R13: Every strobe output is high for exactly one cycle per triggering write. At most one of resp_valid_o, kbd_tx_valid_o and aux_tx_valid_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe |
| wr_cmd_i | input | 1 | 1 = command target, 0 = data target |
| wr_data_i | input | 8 | Written byte |
| mode_o | output | 8 | Mode register |
| outport_o | output | 8 | Output port register |
| status_o | output | 8 | Static status bits |
| a20_o | output | 1 | A20 gate level |
| xlate_en_o | output | 1 | Scan-code translation enable |
| sys_reset_o | output | 1 | System reset request pulse |
| irq_refresh_o | output | 1 | Mode write hint for interrupt logic |
| pend_eval_o | output | 1 | Re-check pending device data |
| resp_valid_o | output | 1 | Response byte strobe |
| resp_data_o | output | 8 | Response byte |
| resp_aux_o | output | 1 | Response is tagged auxiliary |
| kbd_tx_valid_o | output | 1 | Byte to keyboard strobe |
| kbd_tx_data_o | output | 8 | Byte to keyboard |
| aux_tx_valid_o | output | 1 | Byte to mouse strobe |
| aux_tx_data_o | output | 8 | Byte to mouse |
| unsup_o | output | 1 | Unsupported command pulse |

## Verification
Every result is due exactly one clock after the edge that samples the write. Register outputs are due then, and so is each strobe. Each strobe must be low again one clock later. The bench applies a write at a falling edge and compares all outputs against its model at the next falling edge. It then idles for one cycle and checks that every strobe has returned to 0. Directed sequences cover the operand handoffs, the pulse family and latch replacement. After them, a seeded random mix of commands and data runs through the same per-write comparison.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int unsigned BW = 8;

  // mode / output port / status bit positions
  localparam int unsigned MODE_KBD_DIS = 4;
  localparam int unsigned MODE_AUX_DIS = 5;
  localparam int unsigned MODE_XLATE   = 6;
  localparam int unsigned OUTP_RUN     = 0;
  localparam int unsigned OUTP_A20     = 1;
  localparam int unsigned STAT_SELFOK  = 2;

  typedef enum logic [3:0] {
    OP_NONE, OP_RD_MODE, OP_RD_OUTP, OP_RD_INP, OP_TEST_ZERO, OP_SELFTEST,
    OP_DIS_AUX, OP_EN_AUX, OP_DIS_KBD, OP_EN_KBD, OP_A20_ON, OP_A20_OFF,
    OP_RESET, OP_NOP, OP_DEFER, OP_UNSUP
  } op_e;

  typedef enum logic [2:0] {
    DEF_NONE, DEF_MODE, DEF_OUTP, DEF_OBUF_KBD, DEF_OBUF_AUX, DEF_AUX_FWD
  } defer_e;
endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
  import kbc_pkg::*;
(
  input  logic [BW-1:0] cmd_i,
  output op_e           op_o,
  output defer_e        defer_o
);
  always_comb begin
    op_o    = OP_UNSUP;
    defer_o = DEF_NONE;
    unique case (cmd_i)
      8'h20: op_o = OP_RD_MODE;
      8'hD0: op_o = OP_RD_OUTP;
      8'hC0: op_o = OP_RD_INP;
      8'hA9, 8'hAB: op_o = OP_TEST_ZERO;
      8'hAA: op_o = OP_SELFTEST;
      8'hA7: op_o = OP_DIS_AUX;
      8'hA8: op_o = OP_EN_AUX;
      8'hAD: op_o = OP_DIS_KBD;
      8'hAE: op_o = OP_EN_KBD;
      8'hDF: op_o = OP_A20_ON;
      8'hDD: op_o = OP_A20_OFF;
      8'h60: begin op_o = OP_DEFER; defer_o = DEF_MODE;     end
      8'hD1: begin op_o = OP_DEFER; defer_o = DEF_OUTP;     end
      8'hD2: begin op_o = OP_DEFER; defer_o = DEF_OBUF_KBD; end
      8'hD3: begin op_o = OP_DEFER; defer_o = DEF_OBUF_AUX; end
      8'hD4: begin op_o = OP_DEFER; defer_o = DEF_AUX_FWD;  end
      default: begin
        // pulse family folds onto reset or no-op
        if (cmd_i[BW-1:BW-4] == 4'hF) op_o = cmd_i[0] ? OP_NOP : OP_RESET;
        else                          op_o = OP_UNSUP;
      end
    endcase
  end
endmodule

// File: rtl/kbc_defer_latch.sv
module kbc_defer_latch
  import kbc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   cmd_wr_i,
  input  defer_e defer_i,
  input  logic   data_wr_i,
  output defer_e pend_o
);
  defer_e pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             pend_q <= DEF_NONE;
    else if (cmd_wr_i && defer_i != DEF_NONE) pend_q <= defer_i;
    else if (data_wr_i)                      pend_q <= DEF_NONE;
  end

  assign pend_o = pend_q;

  assert_latch_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr_i |=> pend_q == DEF_NONE);
  assert_latch_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && defer_i != DEF_NONE) |=> pend_q == $past(defer_i));
endmodule

// File: rtl/kbc_ctrl_regs.sv
module kbc_ctrl_regs
  import kbc_pkg::*;
#(
  parameter logic [BW-1:0] MODE_RST = 8'h03,
  parameter logic [BW-1:0] OUTP_RST = 8'hCF,
  parameter logic [BW-1:0] STAT_RST = 8'h18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_wr_i,
  input  op_e           op_i,
  input  logic          data_wr_i,
  input  defer_e        pend_i,
  input  logic [BW-1:0] data_i,
  output logic [BW-1:0] mode_o,
  output logic [BW-1:0] outport_o,
  output logic [BW-1:0] status_o,
  output logic          sys_reset_o,
  output logic          irq_refresh_o,
  output logic          pend_eval_o
);
  logic [BW-1:0] mode_q, outp_q, stat_q;
  logic          rst_q, irqr_q, peval_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_RST;
      outp_q  <= OUTP_RST;
      stat_q  <= STAT_RST;
      rst_q   <= 1'b0;
      irqr_q  <= 1'b0;
      peval_q <= 1'b0;
    end else begin
      rst_q   <= 1'b0;
      irqr_q  <= 1'b0;
      peval_q <= 1'b0;
      if (cmd_wr_i) begin
        case (op_i)
          OP_SELFTEST: stat_q[STAT_SELFOK] <= 1'b1;
          OP_DIS_AUX:  mode_q[MODE_AUX_DIS] <= 1'b1;
          OP_EN_AUX:   begin mode_q[MODE_AUX_DIS] <= 1'b0; peval_q <= 1'b1; end
          OP_DIS_KBD:  mode_q[MODE_KBD_DIS] <= 1'b1;
          OP_EN_KBD:   begin mode_q[MODE_KBD_DIS] <= 1'b0; peval_q <= 1'b1; end
          OP_A20_ON:   outp_q[OUTP_A20] <= 1'b1;
          OP_A20_OFF:  outp_q[OUTP_A20] <= 1'b0;
          OP_RESET:    rst_q <= 1'b1;
          default: ;
        endcase
      end else if (data_wr_i) begin
        case (pend_i)
          DEF_NONE:    begin mode_q[MODE_KBD_DIS] <= 1'b0; peval_q <= 1'b1; end
          DEF_MODE:    begin mode_q <= data_i; irqr_q <= 1'b1; peval_q <= 1'b1; end
          DEF_OUTP:    begin outp_q <= data_i; rst_q <= ~data_i[OUTP_RUN]; end
          DEF_AUX_FWD: begin mode_q[MODE_AUX_DIS] <= 1'b0; peval_q <= 1'b1; end
          default: ;
        endcase
      end
    end
  end

  assign mode_o        = mode_q;
  assign outport_o     = outp_q;
  assign status_o      = stat_q;
  assign sys_reset_o   = rst_q;
  assign irq_refresh_o = irqr_q;
  assign pend_eval_o   = peval_q;

  assert_selftest_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && op_i == OP_SELFTEST) |=> stat_q[STAT_SELFOK]);
  assert_aux_dis_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && op_i == OP_DIS_AUX) |=> mode_q[MODE_AUX_DIS]);
  assert_kbd_en_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && op_i == OP_EN_KBD) |=> !mode_q[MODE_KBD_DIS] && peval_q);
  assert_pulse_rst_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && op_i == OP_RESET) |=> rst_q);
  assert_a20_on_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && op_i == OP_A20_ON) |=> outp_q[OUTP_A20]);
  assert_a20_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && op_i == OP_A20_OFF) |=> !outp_q[OUTP_A20]);
  assert_outp_wr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr_i && pend_i == DEF_OUTP) |=> outp_q == $past(data_i));
  assert_kbd_fwd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr_i && pend_i == DEF_NONE) |=> !mode_q[MODE_KBD_DIS]);
  assert_aux_fwd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr_i && pend_i == DEF_AUX_FWD) |=> !mode_q[MODE_AUX_DIS]);
  assert_mode_wr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr_i && pend_i == DEF_MODE) |=> mode_q == $past(data_i) && irqr_q);
  assert_rst_src_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |-> $past(cmd_wr_i || data_wr_i));
endmodule

// File: rtl/kbc_resp_gen.sv
module kbc_resp_gen
  import kbc_pkg::*;
#(
  parameter logic [BW-1:0] SELFTEST_OK = 8'h55,
  parameter logic [BW-1:0] INPORT_VAL  = 8'h80,
  parameter logic [BW-1:0] IF_TEST_OK  = 8'h00
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_wr_i,
  input  op_e           op_i,
  input  logic          data_wr_i,
  input  defer_e        pend_i,
  input  logic [BW-1:0] data_i,
  input  logic [BW-1:0] mode_i,
  input  logic [BW-1:0] outport_i,
  output logic          resp_valid_o,
  output logic [BW-1:0] resp_data_o,
  output logic          resp_aux_o,
  output logic          kbd_tx_valid_o,
  output logic [BW-1:0] kbd_tx_data_o,
  output logic          aux_tx_valid_o,
  output logic [BW-1:0] aux_tx_data_o,
  output logic          unsup_o
);
  logic          rv_d, ra_d, kv_d, av_d, un_d;
  logic [BW-1:0] rd_d;
  logic          rv_q, ra_q, kv_q, av_q, un_q;
  logic [BW-1:0] rd_q, kd_q, ad_q;

  always_comb begin
    rv_d = 1'b0; ra_d = 1'b0; kv_d = 1'b0; av_d = 1'b0; un_d = 1'b0;
    rd_d = '0;
    if (cmd_wr_i) begin
      case (op_i)
        OP_RD_MODE:   begin rv_d = 1'b1; rd_d = mode_i;      end
        OP_RD_OUTP:   begin rv_d = 1'b1; rd_d = outport_i;   end
        OP_RD_INP:    begin rv_d = 1'b1; rd_d = INPORT_VAL;  end
        OP_TEST_ZERO: begin rv_d = 1'b1; rd_d = IF_TEST_OK;  end
        OP_SELFTEST:  begin rv_d = 1'b1; rd_d = SELFTEST_OK; end
        OP_UNSUP:     un_d = 1'b1;
        default: ;
      endcase
    end else if (data_wr_i) begin
      case (pend_i)
        DEF_NONE:     kv_d = 1'b1;
        DEF_OBUF_KBD: begin rv_d = 1'b1; rd_d = data_i; end
        DEF_OBUF_AUX: begin rv_d = 1'b1; rd_d = data_i; ra_d = 1'b1; end
        DEF_AUX_FWD:  av_d = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rv_q <= 1'b0; ra_q <= 1'b0; kv_q <= 1'b0; av_q <= 1'b0; un_q <= 1'b0;
      rd_q <= '0; kd_q <= '0; ad_q <= '0;
    end else begin
      rv_q <= rv_d; ra_q <= ra_d; kv_q <= kv_d; av_q <= av_d; un_q <= un_d;
      rd_q <= rd_d;
      if (kv_d) kd_q <= data_i;
      if (av_d) ad_q <= data_i;
    end
  end

  assign resp_valid_o   = rv_q;
  assign resp_data_o    = rd_q;
  assign resp_aux_o     = ra_q;
  assign kbd_tx_valid_o = kv_q;
  assign kbd_tx_data_o  = kd_q;
  assign aux_tx_valid_o = av_q;
  assign aux_tx_data_o  = ad_q;
  assign unsup_o        = un_q;

  assert_strobe_excl_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rv_q, kv_q, av_q}));
  assert_obuf_aux_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr_i && pend_i == DEF_OBUF_AUX) |=> rv_q && ra_q && rd_q == $past(data_i));
  assert_kbd_data_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr_i && pend_i == DEF_NONE) |=> kv_q && kd_q == $past(data_i));
endmodule

// File: rtl/kbc_cmd_front.sv
module kbc_cmd_front
  import kbc_pkg::*;
#(
  parameter logic [7:0] MODE_RST    = 8'h03,
  parameter logic [7:0] OUTP_RST    = 8'hCF,
  parameter logic [7:0] STAT_RST    = 8'h18,
  parameter logic [7:0] SELFTEST_OK = 8'h55,
  parameter logic [7:0] INPORT_VAL  = 8'h80,
  parameter logic [7:0] IF_TEST_OK  = 8'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       wr_cmd_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] mode_o,
  output logic [7:0] outport_o,
  output logic [7:0] status_o,
  output logic       a20_o,
  output logic       xlate_en_o,
  output logic       sys_reset_o,
  output logic       irq_refresh_o,
  output logic       pend_eval_o,
  output logic       resp_valid_o,
  output logic [7:0] resp_data_o,
  output logic       resp_aux_o,
  output logic       kbd_tx_valid_o,
  output logic [7:0] kbd_tx_data_o,
  output logic       aux_tx_valid_o,
  output logic [7:0] aux_tx_data_o,
  output logic       unsup_o
);
  logic   cmd_wr, data_wr;
  op_e    op;
  defer_e dec_defer, pend;

  assign cmd_wr  = wr_en_i &  wr_cmd_i;
  assign data_wr = wr_en_i & ~wr_cmd_i;

  kbc_cmd_decode i_dec (.cmd_i(wr_data_i), .op_o(op), .defer_o(dec_defer));

  kbc_defer_latch i_latch (
    .clk_i, .rst_ni, .cmd_wr_i(cmd_wr), .defer_i(dec_defer),
    .data_wr_i(data_wr), .pend_o(pend)
  );

  kbc_ctrl_regs #(.MODE_RST(MODE_RST), .OUTP_RST(OUTP_RST), .STAT_RST(STAT_RST)) i_regs (
    .clk_i, .rst_ni, .cmd_wr_i(cmd_wr), .op_i(op), .data_wr_i(data_wr),
    .pend_i(pend), .data_i(wr_data_i), .mode_o, .outport_o, .status_o,
    .sys_reset_o, .irq_refresh_o, .pend_eval_o
  );

  kbc_resp_gen #(.SELFTEST_OK(SELFTEST_OK), .INPORT_VAL(INPORT_VAL),
                 .IF_TEST_OK(IF_TEST_OK)) i_resp (
    .clk_i, .rst_ni, .cmd_wr_i(cmd_wr), .op_i(op), .data_wr_i(data_wr),
    .pend_i(pend), .data_i(wr_data_i), .mode_i(mode_o), .outport_i(outport_o),
    .resp_valid_o, .resp_data_o, .resp_aux_o, .kbd_tx_valid_o, .kbd_tx_data_o,
    .aux_tx_valid_o, .aux_tx_data_o, .unsup_o
  );

  assign a20_o      = outport_o[OUTP_A20];
  assign xlate_en_o = mode_o[MODE_XLATE];

  assert_unsup_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unsup_o |-> $stable(mode_o) && $stable(outport_o) && $stable(status_o));
  assert_unsup_keep_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && op == OP_UNSUP) |=> pend == $past(pend));
  assert_defer_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && op == OP_DEFER) |=> !resp_valid_o && !sys_reset_o && $stable(mode_o));
endmodule

// File: tb/test_kbc_cmd_front.sv
module test_kbc_cmd_front;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_cmd = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] mode, outp, stat, rdata, kdata, adata;
  logic a20, xl, srst, irqr, peval, rvalid, raux, kvalid, avalid, unsup;

  always #5 clk = ~clk;

  kbc_cmd_front i_kbc_cmd_front (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_cmd_i(wr_cmd), .wr_data_i(wr_data),
    .mode_o(mode), .outport_o(outp), .status_o(stat), .a20_o(a20), .xlate_en_o(xl),
    .sys_reset_o(srst), .irq_refresh_o(irqr), .pend_eval_o(peval),
    .resp_valid_o(rvalid), .resp_data_o(rdata), .resp_aux_o(raux),
    .kbd_tx_valid_o(kvalid), .kbd_tx_data_o(kdata),
    .aux_tx_valid_o(avalid), .aux_tx_data_o(adata), .unsup_o(unsup)
  );

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  // model state
  logic [7:0] m_mode = 8'h03, m_outp = 8'hCF, m_stat = 8'h18;
  int m_pend = 0; // 0 none,1 mode,2 outp,3 obuf kbd,4 obuf aux,5 aux fwd
  bit e_rv, e_ra, e_kv, e_av, e_un, e_rst, e_irq, e_pev;
  logic [7:0] e_rd, e_kd, e_ad;

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic bit is_unsup(logic [7:0] c);
    case (c)
      8'h20, 8'hD0, 8'hC0, 8'hA9, 8'hAB, 8'hAA, 8'hA7, 8'hA8, 8'hAD, 8'hAE,
      8'hDF, 8'hDD, 8'h60, 8'hD1, 8'hD2, 8'hD3, 8'hD4: return 1'b0;
      default: return c[7:4] != 4'hF;
    endcase
  endfunction

  task automatic model(bit is_cmd, logic [7:0] d);
    {e_rv, e_ra, e_kv, e_av, e_un, e_rst, e_irq, e_pev} = '0;
    e_rd = 8'h00;
    if (is_cmd) begin
      case (d)
        8'h20: begin e_rv = 1; e_rd = m_mode; end
        8'hD0: begin e_rv = 1; e_rd = m_outp; end
        8'hC0: begin e_rv = 1; e_rd = 8'h80; end
        8'hA9, 8'hAB: begin e_rv = 1; e_rd = 8'h00; end
        8'hAA: begin e_rv = 1; e_rd = 8'h55; m_stat[2] = 1'b1; end
        8'hA7: m_mode[5] = 1'b1;
        8'hA8: begin m_mode[5] = 1'b0; e_pev = 1; end
        8'hAD: m_mode[4] = 1'b1;
        8'hAE: begin m_mode[4] = 1'b0; e_pev = 1; end
        8'hDF: m_outp[1] = 1'b1;
        8'hDD: m_outp[1] = 1'b0;
        8'h60: m_pend = 1;
        8'hD1: m_pend = 2;
        8'hD2: m_pend = 3;
        8'hD3: m_pend = 4;
        8'hD4: m_pend = 5;
        default: begin
          if (d[7:4] == 4'hF) e_rst = !d[0];
          else e_un = 1;
        end
      endcase
    end else begin
      case (m_pend)
        0: begin e_kv = 1; e_kd = d; m_mode[4] = 1'b0; e_pev = 1; end
        1: begin m_mode = d; e_irq = 1; e_pev = 1; end
        2: begin m_outp = d; e_rst = !d[0]; end
        3: begin e_rv = 1; e_rd = d; end
        4: begin e_rv = 1; e_rd = d; e_ra = 1; end
        default: begin e_av = 1; e_ad = d; m_mode[5] = 1'b0; e_pev = 1; end
      endcase
      m_pend = 0;
    end
  endtask

  task automatic chk_all(string tag);
    check({tag, " mode"}, mode, m_mode);
    check({tag, " outport"}, outp, m_outp);
    check({tag, " status"}, stat, m_stat);
    check({tag, " a20"}, a20, m_outp[1]);
    check("R10 xlate", xl, m_mode[6]);
    check({tag, " rst"}, srst, e_rst);
    check("R10 irq_refresh", irqr, e_irq);
    check({tag, " pend_eval"}, peval, e_pev);
    check({tag, " resp_valid"}, rvalid, e_rv);
    if (e_rv) begin
      check({tag, " resp_data"}, rdata, e_rd);
      check("R11 resp_aux", raux, e_ra);
    end
    check("R8 kbd_valid", kvalid, e_kv);
    if (e_kv) check("R8 kbd_data", kdata, e_kd);
    check("R9 aux_valid", avalid, e_av);
    if (e_av) check("R9 aux_data", adata, e_ad);
    check("R12 unsup", unsup, e_un);
  endtask

  task automatic wr(bit is_cmd, logic [7:0] d, string tag);
    wr_en = 1'b1; wr_cmd = is_cmd; wr_data = d;
    model(is_cmd, d);
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    chk_all(tag);
    @(posedge clk); @(negedge clk);
    check("R13 strobes low", {srst, irqr, peval, rvalid, kvalid, avalid, unsup}, 0);
  endtask

  function automatic logic [7:0] pick_cmd(int i);
    case (i)
      0: return 8'h20;  1: return 8'hD0;  2: return 8'hC0;  3: return 8'hA9;
      4: return 8'hAB;  5: return 8'hAA;  6: return 8'hA7;  7: return 8'hA8;
      8: return 8'hAD;  9: return 8'hAE; 10: return 8'hDF; 11: return 8'hDD;
      12: return 8'h60; 13: return 8'hD1; 14: return 8'hD2; 15: return 8'hD3;
      16: return 8'hD4; 17: return 8'hFE; 18: return 8'hFF; 19: return 8'hF6;
      20: return 8'hF3; 21: return 8'h00; 22: return 8'hC1; default: return 8'hE0;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED_1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 mode", mode, 8'h03);
    check("R1 status", stat, 8'h18);
    check("R1 outport", outp, 8'hCF);
    check("R1 a20", a20, 1);
    check("R1 strobes", {srst, irqr, peval, rvalid, kvalid, avalid, unsup}, 0);

    wr(1, 8'h20, "R3");
    wr(1, 8'hAA, "R3");
    wr(1, 8'hC0, "R3");
    wr(1, 8'hA9, "R3");
    wr(1, 8'hAB, "R3");
    wr(1, 8'hD0, "R3");
    wr(1, 8'hAD, "R4");
    wr(0, 8'hF4, "R8");
    wr(1, 8'hA7, "R4");
    wr(1, 8'hA8, "R4");
    wr(1, 8'hAD, "R4");
    wr(1, 8'hAE, "R4");
    wr(1, 8'hA7, "R9");
    wr(1, 8'hD4, "R2");
    wr(0, 8'hE8, "R9");
    wr(0, 8'hED, "R8");
    wr(1, 8'h60, "R2");
    wr(0, 8'h45, "R10");
    wr(1, 8'h20, "R3");
    wr(1, 8'hD2, "R2");
    wr(0, 8'h12, "R11");
    wr(1, 8'hD3, "R2");
    wr(0, 8'h34, "R11");
    wr(1, 8'hDD, "R6");
    wr(1, 8'hDF, "R6");
    wr(1, 8'hD1, "R2");
    wr(0, 8'hCC, "R7");
    wr(1, 8'hD1, "R2");
    wr(0, 8'hCF, "R7");
    wr(1, 8'hFE, "R5");
    wr(1, 8'hF1, "R5");
    wr(1, 8'hF4, "R5");
    wr(1, 8'hFF, "R5");
    wr(1, 8'h60, "R2");
    wr(1, 8'h13, "R12");
    wr(0, 8'h01, "R12");
    wr(1, 8'h60, "R2");
    wr(1, 8'hD4, "R2");
    wr(0, 8'h77, "R2");
    check("R12 decode model", is_unsup(8'h13), 1);

    for (int i = 0; i < 800; i++) begin
      bit c;
      c = ($urandom % 2) == 0;
      if (c) wr(1, pick_cmd(int'($urandom % 24)), "R2");
      else   wr(0, 8'($urandom), "R2");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule